// File: doc/BRIEF.md
# Single-Entry Exception Dispatch Unit

This block keeps the architectural state that a processor needs to take exceptions and interrupts through one shared entry point. There is no ladder of per-level vectors and no bank of per-level saved PCs. When the pipeline raises a dispatch request while dispatch is enabled, the block saves the interrupted PC, the cause code with its info field and, for memory-fault causes only, the faulting address. It then closes the dispatch gate, records a dispatch state and, one cycle later, emits a redirect PC. That PC is taken from either the aligned vector base or an indirect vector register, chosen per request.

Software sees the state through a special-register port that supports read, write and exchange, addressed by 8-bit selectors. A return request sends the pipeline back to the saved PC and reopens the gate. The stack base and stack-limit registers are stored and read back only. No limit checking happens here.

Top module: `exc_dispatch_unit`

## Requirements
- R1: After synchronous reset, every register reads 0, except the mode register, which reads 0x20 (enable bit set, state 0). `redirect_valid` is 0 and `dispatch_en` is 1.
- R2: A request with `dsp_req`=1 while the enable bit is 1 is accepted. On the next cycle the saved-PC register (selector 0xb1) holds `dsp_pc`. The cause register (0xe8) holds `dsp_cause` in bits [15:0] and `dsp_info` in bits [20:16]. The mode register (0xe5) holds `dsp_state` in bits [4:0] with the enable bit [5] cleared.
- R3: The fault-address register (0xee) is loaded with `dsp_vaddr` on an accepted dispatch only when the cause lies in 0x0010..0x001F. For any other cause it keeps its value.
- R4: A dispatch request made while the enable bit is 0 is ignored. No register changes and no redirect is issued.
- R5: One cycle after an accepted dispatch, `redirect_valid` is 1 for that cycle. `redirect_pc` is the indirect vector register (0x74) if `dsp_indirect`=1, otherwise the vector base register (0xe7). Both values are taken as they stood in the accept cycle. When `redirect_valid` is 0, `redirect_pc` is 0.
- R6: Cause code 0 is accepted and captured like any other cause.
- R7: A return request (`ret_req`=1) issues a redirect to the saved PC on the next cycle and sets the enable bit, leaving the dispatch state unchanged. An accepted dispatch in the same cycle takes priority and the return is dropped.
- R8: `sr_op` encodes 0 idle, 1 read, 2 write and 3 exchange. The selectors are 0xb1, 0xe8, 0xee, 0xe5, 0xe7, 0x74, 0xec (stack base), 0xf8 (interrupt-stack limit) and 0xf9 (kernel-stack limit). Any other selector reads 0 and a write to it changes nothing. `sr_rdata` is 0 unless the op is read or exchange.
- R9: Unimplemented bits read 0: mode [31:6], vector base [5:0] and cause [31:21].
- R10: A write takes effect on the next cycle. An exchange returns the old value in the same cycle and stores the new value.
- R11: If a hardware capture (dispatch or return) and a software write target the same register in the same cycle, the hardware value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| dsp_req | input | 1 | dispatch request |
| dsp_pc | input | 32 | interrupted PC |
| dsp_cause | input | 16 | cause code |
| dsp_info | input | 5 | cause info |
| dsp_vaddr | input | 32 | faulting address |
| dsp_state | input | 5 | dispatch state to record |
| dsp_indirect | input | 1 | use indirect vector for redirect |
| ret_req | input | 1 | dispatch return request |
| sr_op | input | 2 | special-register operation |
| sr_sel | input | 8 | special-register selector |
| sr_wdata | input | 32 | write / exchange data |
| sr_rdata | output | 32 | read / exchange old value |
| redirect_valid | output | 1 | redirect strobe |
| redirect_pc | output | 32 | redirect target |
| dispatch_en | output | 1 | current dispatch-enable bit |

## Verification
A wrong captured value stays hidden until software reads it or a return uses it. The bench therefore mixes selector reads and returns into random traffic, so a bad saved PC shows up as a wrong `redirect_pc` one cycle after the return. A gate that fails to close or reopen shows at `dispatch_en` on the cycle after the event, and also as an extra or missing `redirect_valid` pulse. Write-collision errors appear as a stale read on the first read that follows.

// File: rtl/exc_disp_pkg.sv
package exc_disp_pkg;

    localparam int XLEN      = 32;
    localparam int CAUSE_W   = 16;
    localparam int INFO_W    = 5;
    localparam int DST_W     = 5;
    localparam int VEC_ALIGN = 6;
    localparam int VB_W      = XLEN - VEC_ALIGN;
    localparam int SEL_W     = 8;

    localparam logic [SEL_W-1:0] SEL_EPC   = 8'hb1;
    localparam logic [SEL_W-1:0] SEL_CAUSE = 8'he8;
    localparam logic [SEL_W-1:0] SEL_VADDR = 8'hee;
    localparam logic [SEL_W-1:0] SEL_MODE  = 8'he5;
    localparam logic [SEL_W-1:0] SEL_VBASE = 8'he7;
    localparam logic [SEL_W-1:0] SEL_IVEC  = 8'h74;
    localparam logic [SEL_W-1:0] SEL_SBASE = 8'hec;
    localparam logic [SEL_W-1:0] SEL_ISLIM = 8'hf8;
    localparam logic [SEL_W-1:0] SEL_KSLIM = 8'hf9;

    typedef enum logic [1:0] {
        SR_IDLE = 2'd0,
        SR_READ = 2'd1,
        SR_WRITE = 2'd2,
        SR_XCHG = 2'd3
    } sr_op_e;

    typedef struct packed {
        logic [XLEN-1:0]    pc;
        logic [CAUSE_W-1:0] cause;
        logic [INFO_W-1:0]  info;
        logic [XLEN-1:0]    vaddr;
        logic [DST_W-1:0]   state;
    } capture_t;

    typedef struct packed {
        logic [XLEN-1:0]    epc;
        logic [CAUSE_W-1:0] cause;
        logic [INFO_W-1:0]  info;
        logic [XLEN-1:0]    vaddr;
        logic               de;
        logic [DST_W-1:0]   dst;
        logic [VB_W-1:0]    vbase;
        logic [XLEN-1:0]    ivec;
        logic [XLEN-1:0]    sbase;
        logic [XLEN-1:0]    islim;
        logic [XLEN-1:0]    kslim;
    } sr_state_t;

    function automatic logic in_range(input logic [CAUSE_W-1:0] c,
                                      input logic [CAUSE_W-1:0] lo,
                                      input logic [CAUSE_W-1:0] hi);
        return (c >= lo) && (c <= hi);
    endfunction

    function automatic logic [XLEN-1:0] vbase_addr(input logic [VB_W-1:0] vb);
        return {vb, {VEC_ALIGN{1'b0}}};
    endfunction

    function automatic logic sel_known(input logic [SEL_W-1:0] s);
        return (s == SEL_EPC) || (s == SEL_CAUSE) || (s == SEL_VADDR) ||
               (s == SEL_MODE) || (s == SEL_VBASE) || (s == SEL_IVEC) ||
               (s == SEL_SBASE) || (s == SEL_ISLIM) || (s == SEL_KSLIM);
    endfunction

endpackage

// File: rtl/exc_dispatch_ctrl.sv
module exc_dispatch_ctrl
    import exc_disp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            dsp_req,
    input  logic            ret_req,
    input  logic            dsp_indirect,
    input  logic            de,
    input  logic [XLEN-1:0] epc,
    input  logic [VB_W-1:0] vbase,
    input  logic [XLEN-1:0] ivec,
    output logic            accept,
    output logic            do_return,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc
);

    logic [XLEN-1:0] target_d;

    // gate: only an enabled core takes a dispatch; dispatch outranks return
    assign accept    = dsp_req && de;
    assign do_return = ret_req && !accept;

    always_comb begin
        target_d = '0;
        if (accept) begin
            target_d = dsp_indirect ? ivec : vbase_addr(vbase);
        end else if (do_return) begin
            target_d = epc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= accept || do_return;
            redirect_pc    <= target_d;
        end
    end

    // R4: blocked request produces no redirect
    assert_blocked_no_redirect_R4: assert property (@(posedge clk) disable iff (rst)
        (dsp_req && !de && !ret_req) |=> !redirect_valid);

    // R7: return targets the saved PC
    assert_return_target_R7: assert property (@(posedge clk) disable iff (rst)
        do_return |=> (redirect_valid && redirect_pc == $past(epc)));

    // R5: direct dispatch lands on an aligned base
    assert_direct_aligned_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && !dsp_indirect) |=> (redirect_pc[VEC_ALIGN-1:0] == '0));

endmodule

// File: rtl/exc_sr_bank.sv
module exc_sr_bank
    import exc_disp_pkg::*;
#(
    parameter logic [CAUSE_W-1:0] MEMF_LO = 16'h0010,
    parameter logic [CAUSE_W-1:0] MEMF_HI = 16'h001F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             do_return,
    input  capture_t         cap,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    output sr_state_t        regs
);

    logic memf;
    logic w_epc, w_cause, w_vaddr, w_mode, w_vbase, w_ivec, w_sbase, w_islim, w_kslim;

    assign memf    = in_range(cap.cause, MEMF_LO, MEMF_HI);
    assign w_epc   = wr_en && (wr_sel == SEL_EPC);
    assign w_cause = wr_en && (wr_sel == SEL_CAUSE);
    assign w_vaddr = wr_en && (wr_sel == SEL_VADDR);
    assign w_mode  = wr_en && (wr_sel == SEL_MODE);
    assign w_vbase = wr_en && (wr_sel == SEL_VBASE);
    assign w_ivec  = wr_en && (wr_sel == SEL_IVEC);
    assign w_sbase = wr_en && (wr_sel == SEL_SBASE);
    assign w_islim = wr_en && (wr_sel == SEL_ISLIM);
    assign w_kslim = wr_en && (wr_sel == SEL_KSLIM);

    // saved PC: hardware capture outranks software write
    always_ff @(posedge clk) begin
        if (rst)          regs.epc <= '0;
        else if (accept)  regs.epc <= cap.pc;
        else if (w_epc)   regs.epc <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.cause <= '0;
            regs.info  <= '0;
        end else if (accept) begin
            regs.cause <= cap.cause;
            regs.info  <= cap.info;
        end else if (w_cause) begin
            regs.cause <= wr_data[CAUSE_W-1:0];
            regs.info  <= wr_data[CAUSE_W+INFO_W-1:CAUSE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  regs.vaddr <= '0;
        else if (accept && memf)  regs.vaddr <= cap.vaddr;
        else if (w_vaddr)         regs.vaddr <= wr_data;
    end

    // mode: dispatch closes the gate, return reopens it, keeping the state
    always_ff @(posedge clk) begin
        if (rst) begin
            regs.de  <= 1'b1;
            regs.dst <= '0;
        end else if (accept) begin
            regs.de  <= 1'b0;
            regs.dst <= cap.state;
        end else if (do_return) begin
            regs.de  <= 1'b1;
        end else if (w_mode) begin
            regs.de  <= wr_data[DST_W];
            regs.dst <= wr_data[DST_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.vbase <= '0;
            regs.ivec  <= '0;
            regs.sbase <= '0;
            regs.islim <= '0;
            regs.kslim <= '0;
        end else begin
            if (w_vbase) regs.vbase <= wr_data[XLEN-1:VEC_ALIGN];
            if (w_ivec)  regs.ivec  <= wr_data;
            if (w_sbase) regs.sbase <= wr_data;
            if (w_islim) regs.islim <= wr_data;
            if (w_kslim) regs.kslim <= wr_data;
        end
    end

    // R2: the single saved PC takes the interrupted PC
    assert_epc_capture_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (regs.epc == $past(cap.pc)));

    // R2: accepted dispatch closes the gate
    assert_gate_close_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !regs.de);

    // R3: fault address untouched for non-memory causes
    assert_vaddr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && !memf && !w_vaddr) |=> $stable(regs.vaddr));

    // R7: return reopens the gate and keeps the state
    assert_rearm_R7: assert property (@(posedge clk) disable iff (rst)
        do_return |=> (regs.de && $stable(regs.dst)));

    // R11: hardware capture wins over a same-cycle cause write
    assert_cause_priority_R11: assert property (@(posedge clk) disable iff (rst)
        (accept && w_cause) |=> (regs.cause == $past(cap.cause)));

endmodule

// File: rtl/exc_sr_rdmux.sv
module exc_sr_rdmux
    import exc_disp_pkg::*;
(
    input  sr_state_t        regs,
    input  logic             rd_en,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [XLEN-1:0]  rd_data
);

    localparam int PAD_CAUSE = XLEN - CAUSE_W - INFO_W;
    localparam int PAD_MODE  = XLEN - DST_W - 1;

    logic [XLEN-1:0] sel_val;

    always_comb begin
        case (rd_sel)
            SEL_EPC:   sel_val = regs.epc;
            SEL_CAUSE: sel_val = {{PAD_CAUSE{1'b0}}, regs.info, regs.cause};
            SEL_VADDR: sel_val = regs.vaddr;
            SEL_MODE:  sel_val = {{PAD_MODE{1'b0}}, regs.de, regs.dst};
            SEL_VBASE: sel_val = vbase_addr(regs.vbase);
            SEL_IVEC:  sel_val = regs.ivec;
            SEL_SBASE: sel_val = regs.sbase;
            SEL_ISLIM: sel_val = regs.islim;
            SEL_KSLIM: sel_val = regs.kslim;
            default:   sel_val = '0;
        endcase
        rd_data = rd_en ? sel_val : '0;
    end

    // R8: unknown selector never returns data
    always_comb begin
        assert_unknown_zero_R8: assert (sel_known(rd_sel) || rd_data == '0);
    end

endmodule

// File: rtl/exc_dispatch_unit.sv
module exc_dispatch_unit
    import exc_disp_pkg::*;
#(
    parameter logic [CAUSE_W-1:0] MEMF_LO = 16'h0010,
    parameter logic [CAUSE_W-1:0] MEMF_HI = 16'h001F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dsp_req,
    input  logic [XLEN-1:0]    dsp_pc,
    input  logic [CAUSE_W-1:0] dsp_cause,
    input  logic [INFO_W-1:0]  dsp_info,
    input  logic [XLEN-1:0]    dsp_vaddr,
    input  logic [DST_W-1:0]   dsp_state,
    input  logic               dsp_indirect,
    input  logic               ret_req,
    input  logic [1:0]         sr_op,
    input  logic [SEL_W-1:0]   sr_sel,
    input  logic [XLEN-1:0]    sr_wdata,
    output logic [XLEN-1:0]    sr_rdata,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic               dispatch_en
);

    sr_state_t regs;
    capture_t  cap;
    logic      accept, do_return, wr_en, rd_en;
    sr_op_e    op;

    assign op    = sr_op_e'(sr_op);
    assign wr_en = (op == SR_WRITE) || (op == SR_XCHG);
    assign rd_en = (op == SR_READ)  || (op == SR_XCHG);

    assign cap.pc    = dsp_pc;
    assign cap.cause = dsp_cause;
    assign cap.info  = dsp_info;
    assign cap.vaddr = dsp_vaddr;
    assign cap.state = dsp_state;

    exc_dispatch_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .dsp_req        (dsp_req),
        .ret_req        (ret_req),
        .dsp_indirect   (dsp_indirect),
        .de             (regs.de),
        .epc            (regs.epc),
        .vbase          (regs.vbase),
        .ivec           (regs.ivec),
        .accept         (accept),
        .do_return      (do_return),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    exc_sr_bank #(.MEMF_LO(MEMF_LO), .MEMF_HI(MEMF_HI)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .do_return (do_return),
        .cap       (cap),
        .wr_en     (wr_en),
        .wr_sel    (sr_sel),
        .wr_data   (sr_wdata),
        .regs      (regs)
    );

    exc_sr_rdmux u_rdmux (
        .regs    (regs),
        .rd_en   (rd_en),
        .rd_sel  (sr_sel),
        .rd_data (sr_rdata)
    );

    assign dispatch_en = regs.de;

    // R9: mode upper bits always read zero
    assert_mode_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sr_sel == SEL_MODE) |-> (sr_rdata[XLEN-1:DST_W+1] == '0));

    // R10: exchange stores the new value by the next cycle
    assert_xchg_store_R10: assert property (@(posedge clk) disable iff (rst)
        (op == SR_XCHG && sr_sel == SEL_IVEC) |=> (regs.ivec == $past(sr_wdata)));

endmodule

// File: tb/exc_dispatch_unit_tb.sv
module exc_dispatch_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        dsp_req;
    logic [31:0] dsp_pc;
    logic [15:0] dsp_cause;
    logic [4:0]  dsp_info;
    logic [31:0] dsp_vaddr;
    logic [4:0]  dsp_state;
    logic        dsp_indirect;
    logic        ret_req;
    logic [1:0]  sr_op;
    logic [7:0]  sr_sel;
    logic [31:0] sr_wdata;
    logic [31:0] sr_rdata;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        dispatch_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_epc, m_cause, m_vaddr, m_mode, m_vb, m_iv, m_sb, m_il, m_kl;

    always #4 clk = ~clk;

    exc_dispatch_unit u_dut (
        .clk(clk), .rst(rst), .dsp_req(dsp_req), .dsp_pc(dsp_pc),
        .dsp_cause(dsp_cause), .dsp_info(dsp_info), .dsp_vaddr(dsp_vaddr),
        .dsp_state(dsp_state), .dsp_indirect(dsp_indirect), .ret_req(ret_req),
        .sr_op(sr_op), .sr_sel(sr_sel), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .dispatch_en(dispatch_en)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] s);
        case (s)
            8'hb1: return m_epc;
            8'he8: return m_cause;
            8'hee: return m_vaddr;
            8'he5: return m_mode;
            8'he7: return m_vb;
            8'h74: return m_iv;
            8'hec: return m_sb;
            8'hf8: return m_il;
            8'hf9: return m_kl;
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit is_memf(input logic [15:0] c);
        return (c >= 16'h0010) && (c <= 16'h001F);
    endfunction

    task automatic m_reset();
        m_epc = 0; m_cause = 0; m_vaddr = 0; m_mode = 32'h20;
        m_vb = 0; m_iv = 0; m_sb = 0; m_il = 0; m_kl = 0;
    endtask

    // one cycle: called at a falling edge, returns at the next falling edge
    task automatic cyc(input bit req, input logic [31:0] pc, input logic [15:0] cause,
                       input logic [4:0] info, input logic [31:0] va, input logic [4:0] st,
                       input bit ind, input bit ret, input logic [1:0] op,
                       input logic [7:0] sel, input logic [31:0] wd, input string tag);
        bit acc, rt;
        logic [31:0] exp_pc;
        dsp_req = req; dsp_pc = pc; dsp_cause = cause; dsp_info = info;
        dsp_vaddr = va; dsp_state = st; dsp_indirect = ind; ret_req = ret;
        sr_op = op; sr_sel = sel; sr_wdata = wd;
        #1;
        check(sr_rdata, (op == 2'd1 || op == 2'd3) ? m_read(sel) : 32'h0, tag);
        acc = req && m_mode[5];
        rt  = ret && !acc;
        exp_pc = acc ? (ind ? m_iv : m_vb) : (rt ? m_epc : 32'h0);
        if (op[1]) begin
            case (sel)
                8'hb1: m_epc = wd;
                8'he8: m_cause = wd & 32'h001F_FFFF;
                8'hee: m_vaddr = wd;
                8'he5: m_mode = wd & 32'h3F;
                8'he7: m_vb = wd & 32'hFFFF_FFC0;
                8'h74: m_iv = wd;
                8'hec: m_sb = wd;
                8'hf8: m_il = wd;
                8'hf9: m_kl = wd;
                default: ;
            endcase
        end
        if (acc) begin
            m_epc = pc;
            m_cause = {11'h0, info, cause};
            if (is_memf(cause)) m_vaddr = va;
            m_mode = {26'h0, 1'b0, st};
        end else if (rt) begin
            m_mode = {26'h0, 1'b1, (op[1] && sel == 8'he5) ? m_mode_prev_state() : m_mode[4:0]};
        end
        @(posedge clk);
        @(negedge clk);
        check({31'h0, redirect_valid}, {31'h0, (acc || rt)}, tag);
        check(redirect_pc, exp_pc, tag);
        check({31'h0, dispatch_en}, {31'h0, m_mode[5]}, tag);
    endtask

    // state bits before a same-cycle software mode write (return wins, R11)
    logic [4:0] pre_state;
    function automatic logic [4:0] m_mode_prev_state();
        return pre_state;
    endfunction

    task automatic step(input bit req, input logic [31:0] pc, input logic [15:0] cause,
                        input logic [4:0] info, input logic [31:0] va, input logic [4:0] st,
                        input bit ind, input bit ret, input logic [1:0] op,
                        input logic [7:0] sel, input logic [31:0] wd, input string tag);
        pre_state = m_mode[4:0];
        cyc(req, pc, cause, info, va, st, ind, ret, op, sel, wd, tag);
    endtask

    task automatic rd(input logic [7:0] sel, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 2'd1, sel, 0, tag);
    endtask

    task automatic wr(input logic [7:0] sel, input logic [31:0] d, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 2'd2, sel, d, tag);
    endtask

    logic [7:0] sels [10] = '{8'hb1, 8'he8, 8'hee, 8'he5, 8'he7, 8'h74, 8'hec, 8'hf8, 8'hf9, 8'h3c};

    initial begin
        int wd_cnt;
        wd_cnt = 0;
        while (!done) begin
            @(posedge clk);
            wd_cnt++;
            if (wd_cnt > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<100000 cycles", wd_cnt);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; dsp_req = 0; dsp_pc = 0; dsp_cause = 0; dsp_info = 0; dsp_vaddr = 0;
        dsp_state = 0; dsp_indirect = 0; ret_req = 0; sr_op = 0; sr_sel = 0; sr_wdata = 0;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset values through every selector
        check({31'h0, dispatch_en}, 32'h1, "R1");
        check({31'h0, redirect_valid}, 32'h0, "R1");
        for (int i = 0; i < 9; i++) rd(sels[i], "R1");

        // R9: masked write fields
        wr(8'he7, 32'hFFFF_FFFF, "R9"); rd(8'he7, "R9");
        wr(8'he8, 32'hFFFF_FFFF, "R9"); rd(8'he8, "R9");
        wr(8'he5, 32'hFFFF_FFFF, "R9"); rd(8'he5, "R9");
        wr(8'he5, 32'h20, "R9");

        // R8: unknown selector, idle op
        wr(8'h3c, 32'hDEAD_BEEF, "R8"); rd(8'h3c, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 8'hb1, 0, "R8");

        // R10: exchange returns old, stores new
        wr(8'h74, 32'h1111_2220, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 0, 2'd3, 8'h74, 32'h0000_4440, "R10");
        rd(8'h74, "R10");
        wr(8'he7, 32'h8000_1234, "R10");

        // R6: cause 0 accepted, direct vector (R5)
        step(1, 32'h0000_1000, 16'h0000, 5'd3, 32'hAAAA_0000, 5'd7, 0, 0, 2'd0, 0, 0, "R6");
        rd(8'he8, "R6"); rd(8'hb1, "R2"); rd(8'he5, "R2"); rd(8'hee, "R3");

        // R4: blocked request
        step(1, 32'h0000_2000, 16'h0011, 5'd1, 32'hBBBB_0000, 5'd9, 1, 0, 2'd0, 0, 0, "R4");
        rd(8'hb1, "R4"); rd(8'hee, "R4");

        // R7: return
        step(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 0, 0, "R7");
        rd(8'he5, "R7");

        // R3: memory fault, indirect (R5)
        step(1, 32'h0000_3000, 16'h0012, 5'd2, 32'hCCCC_0004, 5'd4, 1, 0, 2'd0, 0, 0, "R3");
        rd(8'hee, "R3");

        // R11: capture vs write to saved PC; return vs write to mode
        step(0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 8'he5, 32'h0000_001F, "R11");
        rd(8'he5, "R11");
        step(1, 32'h0000_5000, 16'h0020, 5'd0, 32'h0, 5'd1, 0, 0, 2'd2, 8'hb1, 32'h9999_9999, "R11");
        rd(8'hb1, "R11");
        // R7: dispatch beats return, then closed gate lets return through
        step(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 0, 0, "R7");
        step(1, 32'h0000_6000, 16'h0001, 5'd0, 32'h0, 5'd2, 0, 1, 2'd0, 0, 0, "R7");
        step(1, 32'h0000_7000, 16'h0001, 5'd0, 32'h0, 5'd2, 0, 1, 2'd0, 0, 0, "R7");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            bit rq, rt, ind;
            logic [15:0] c;
            logic [1:0] op;
            logic [7:0] s;
            rq  = ($urandom_range(0, 9) < 3);
            rt  = ($urandom_range(0, 9) < 2);
            ind = $urandom_range(0, 1);
            case ($urandom_range(0, 3))
                0: c = 16'h0000;
                1: c = 16'h0010 + 16'($urandom_range(0, 15));
                2: c = 16'h000F + 16'(17 * $urandom_range(0, 1));
                default: c = 16'($urandom);
            endcase
            op = 2'($urandom_range(0, 3));
            s  = sels[$urandom_range(0, 9)];
            step(rq, $urandom, c, 5'($urandom), $urandom, 5'($urandom), ind, rt, op, s,
                 $urandom, "R8");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule